// File: doc/BRIEF.md
# Display Line Address and Panning Generator

This block produces frame-buffer word addresses for a raster refresh engine that shows two screen regions stacked vertically. A timing generator supplies three strobes: one at the start of each frame, one at the start of each later scan line, and one for each word fetched within a line. From these the block keeps a line base address and a running word address. It also reports how many pixels the pixel unpacker should drop from the left of the line.

Each screen region has its own start word address and its own 4-bit pan value. A shared line stride, counted in memory words, is added to the base at every new line. When the stride is wider than the panel, the visible area is a window onto a wider virtual image. Horizontal scrolling at pixel resolution comes from moving the start word address and the pan value together. The pan bits that take effect depend on the colour depth.

Configuration arrives as byte writes to a small index space. The writes are held in pending registers and are copied to the active set only at a frame start, so a frame is never drawn with mixed settings.

Top module: `scanline_addr_pan_gen`

## Requirements
- R1: While rst_n is low at a clock edge, mem_addr, pan_count and screen_sel become 0. All pending and active settings clear to 0, so a frame started right after reset begins at word 0 with no shift.
- R2: frame_start loads mem_addr and the line base with the pending screen-1 start address. It sets screen_sel to 0, restarts the line index at 0 and copies every pending setting into the active set. All outputs show the result after that clock edge.
- R3: word_strobe alone advances mem_addr by one word, modulo 2^ADDR_W.
- R4: line_start (without frame_start) sets the line base and mem_addr to the previous line base plus the active 11-bit stride, modulo 2^ADDR_W. Any word steps taken inside the previous line are discarded.
- R5: On a line_start where screen_sel is 0 and the new line index (line 0 is the frame-start line) equals a non-zero active split value, the line base and mem_addr reload from the active screen-2 start address and screen_sel becomes 1. Later lines add the stride from that base. A split value of 0 never switches.
- R6: pan_count is the pan value of the current screen ANDed with a mask set by the active depth code. The masks are: code 0 (1 bpp) 4'hF, code 1 (2 bpp) 4'h7, code 2 (4 bpp) 4'h3, code 3 (8 bpp) 4'h1, and codes 4 to 7 (15/16 bpp) 4'h0.
- R7: A configuration write changes no output until the next frame_start. A write in the same cycle as a frame_start is not part of the set copied at that edge.
- R8: The write index map is: 0 holds stride[7:0]; 1 holds stride[10:8] in data bits 2..0; 2 holds the screen-2 pan in bits 7..4 and the screen-1 pan in bits 3..0; 3 holds the depth code in bits 2..0; 4, 5 and 6 hold screen-1 start address bytes, least significant first; 8, 9 and 10 hold screen-2 start address bytes in the same order; 12 and 13 hold the split line index, low byte first. Writes to any other index have no effect.
- R9: When strobes coincide, frame_start wins over line_start, and line_start wins over word_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_idx | input | 4 | Configuration byte index |
| cfg_wdata | input | 8 | Configuration byte value |
| frame_start | input | 1 | Start of frame (also the start of line 0) |
| line_start | input | 1 | Start of each following scan line |
| word_strobe | input | 1 | Advance to the next word of the line |
| mem_addr | output | ADDR_W (20) | Current frame-buffer word address |
| pan_count | output | 4 | Effective left pan in pixels |
| screen_sel | output | 1 | 0 while drawing screen 1, 1 after the split |

## Verification
The assertions assume that the strobes are single-cycle pulses and that the timing generator may assert them together. The line-step and word-step properties therefore exclude the cycles in which a higher-priority strobe overrides them. They also assume the split can only happen once per frame. The bench drives each strobe for exactly one cycle, combines strobes only in the tests that target priority, and writes configuration between strobes except in the one test of a write that coincides with a frame start.

// File: rtl/sapg_pkg.sv
// Shared constants for the scan-line address and pan generator.
// Assumes an 8-bit configuration data path and a 4-bit pan field.
package sapg_pkg;

    localparam int PAN_W   = 4;
    localparam int DEPTH_W = 3;

    // Configuration index map (byte writes)
    localparam int IDX_STRIDE = 0;   // 0: low byte, 1: high bits
    localparam int IDX_PAN    = 2;
    localparam int IDX_DEPTH  = 3;
    localparam int IDX_S1     = 4;   // 4..6
    localparam int IDX_S2     = 8;   // 8..10
    localparam int IDX_SPLIT  = 12;  // 12..13

    typedef enum logic [DEPTH_W-1:0] {
        DEPTH_1BPP  = 3'd0,
        DEPTH_2BPP  = 3'd1,
        DEPTH_4BPP  = 3'd2,
        DEPTH_8BPP  = 3'd3,
        DEPTH_16BPP = 3'd4
    } depth_e;

    // Mask of pan bits that take effect at a given colour depth
    function automatic logic [PAN_W-1:0] pan_mask(input logic [DEPTH_W-1:0] depth);
        case (depth)
            DEPTH_1BPP: pan_mask = 4'hF;
            DEPTH_2BPP: pan_mask = 4'h7;
            DEPTH_4BPP: pan_mask = 4'h3;
            DEPTH_8BPP: pan_mask = 4'h1;
            default:    pan_mask = 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/sapg_cfg_regs.sv
// Configuration store: pending byte-written registers and an active
// shadow set that is refreshed only at frame_start.
// Assumes each multi-byte field fits inside its index range (ADDR_W <= 24,
// LINE_W <= 16, 9 <= STRIDE_W <= 16).
module sapg_cfg_regs
    import sapg_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int STRIDE_W = 11,
    parameter int LINE_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          wr_idx,
    input  logic [7:0]          wr_data,
    input  logic                frame_start,
    output logic [ADDR_W-1:0]   pend_s1,
    output logic [ADDR_W-1:0]   act_s2,
    output logic [STRIDE_W-1:0] act_stride,
    output logic [LINE_W-1:0]   act_split,
    output logic [PAN_W-1:0]    act_pan1,
    output logic [PAN_W-1:0]    act_pan2,
    output logic [DEPTH_W-1:0]  act_depth
);

    logic [ADDR_W-1:0]   pend_s2;
    logic [STRIDE_W-1:0] pend_stride;
    logic [LINE_W-1:0]   pend_split;
    logic [PAN_W-1:0]    pend_pan1;
    logic [PAN_W-1:0]    pend_pan2;
    logic [DEPTH_W-1:0]  pend_depth;

    // Pending registers: accept byte writes, one bit at a time by index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_s1     <= '0;
            pend_s2     <= '0;
            pend_stride <= '0;
            pend_split  <= '0;
            pend_pan1   <= '0;
            pend_pan2   <= '0;
            pend_depth  <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < ADDR_W; b++) begin
                if (int'(wr_idx) == IDX_S1 + b / 8) pend_s1[b] <= wr_data[b % 8];
                if (int'(wr_idx) == IDX_S2 + b / 8) pend_s2[b] <= wr_data[b % 8];
            end
            for (int b = 0; b < STRIDE_W; b++) begin
                if (int'(wr_idx) == IDX_STRIDE + b / 8) pend_stride[b] <= wr_data[b % 8];
            end
            for (int b = 0; b < LINE_W; b++) begin
                if (int'(wr_idx) == IDX_SPLIT + b / 8) pend_split[b] <= wr_data[b % 8];
            end
            if (int'(wr_idx) == IDX_PAN) begin
                pend_pan1 <= wr_data[PAN_W-1:0];
                pend_pan2 <= wr_data[2*PAN_W-1:PAN_W];
            end
            if (int'(wr_idx) == IDX_DEPTH) begin
                pend_depth <= wr_data[DEPTH_W-1:0];
            end
        end
    end

    // Active set: copy the pending set at frame start only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_s2     <= '0;
            act_stride <= '0;
            act_split  <= '0;
            act_pan1   <= '0;
            act_pan2   <= '0;
            act_depth  <= '0;
        end else if (frame_start) begin
            act_s2     <= pend_s2;
            act_stride <= pend_stride;
            act_split  <= pend_split;
            act_pan1   <= pend_pan1;
            act_pan2   <= pend_pan2;
            act_depth  <= pend_depth;
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_stride) && $stable(act_s2) && $stable(act_split)
                          && $stable(act_pan1) && $stable(act_pan2) && $stable(act_depth))); // R7

endmodule

// File: rtl/sapg_line_walker.sv
// Line base and word address walker. Loads screen 1 at frame start, adds
// the stride at each line start, reloads screen 2 at the split line, and
// steps one word per word strobe. Addresses wrap modulo 2^ADDR_W.
// Assumes strobes are single-cycle; priority is frame > line > word.
module sapg_line_walker #(
    parameter int ADDR_W   = 20,
    parameter int STRIDE_W = 11,
    parameter int LINE_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic                word_strobe,
    input  logic [ADDR_W-1:0]   s1_start,
    input  logic [ADDR_W-1:0]   s2_start,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [LINE_W-1:0]   split_line,
    output logic [ADDR_W-1:0]   word_addr,
    output logic                screen
);

    localparam int PAD_W = ADDR_W - STRIDE_W;

    logic [ADDR_W-1:0] line_base;
    logic [LINE_W-1:0] line_idx;
    logic [LINE_W-1:0] next_idx;
    logic [ADDR_W-1:0] step_base;
    logic              split_hit;

    // Next-line index, stepped base and split detection
    always_comb begin
        next_idx  = line_idx + 1'b1;
        step_base = line_base + {{PAD_W{1'b0}}, stride};
        split_hit = !screen && (split_line != '0) && (next_idx == split_line);
    end

    // Address state: frame load, line step or split reload, word step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
            word_addr <= '0;
            line_idx  <= '0;
            screen    <= 1'b0;
        end else if (frame_start) begin
            line_base <= s1_start;
            word_addr <= s1_start;
            line_idx  <= '0;
            screen    <= 1'b0;
        end else if (line_start) begin
            line_idx <= next_idx;
            if (split_hit) begin
                line_base <= s2_start;
                word_addr <= s2_start;
                screen    <= 1'b1;
            end else begin
                line_base <= step_base;
                word_addr <= step_base;
            end
        end else if (word_strobe) begin
            word_addr <= word_addr + 1'b1;
        end
    end

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && !line_start && !frame_start) |=> word_addr == $past(word_addr) + 1'b1); // R3

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && !split_hit)
            |=> word_addr == $past(line_base) + {{PAD_W{1'b0}}, $past(stride)}); // R4

    AST_SPLIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && split_hit) |=> (screen && word_addr == $past(s2_start))); // R5

    AST_SCREEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (screen && !frame_start) |=> screen); // R5

endmodule

// File: rtl/sapg_pan_sel.sv
// Pan selection: picks the pan of the screen being drawn and masks it by
// the colour depth. Purely combinational; assumes inputs are registered.
module sapg_pan_sel
    import sapg_pkg::*;
(
    input  logic               screen,
    input  logic [PAN_W-1:0]   pan1,
    input  logic [PAN_W-1:0]   pan2,
    input  logic [DEPTH_W-1:0] depth,
    output logic [PAN_W-1:0]   pan_out
);

    // Screen mux followed by the depth mask
    always_comb begin
        pan_out = (screen ? pan2 : pan1) & pan_mask(depth);
    end

endmodule

// File: rtl/scanline_addr_pan_gen.sv
// Top level: frame-buffer word address and pan count for a two-screen
// raster refresh. Assumes frame/line/word strobes from a timing generator,
// each one clock wide; configuration is staged until the next frame start.
module scanline_addr_pan_gen
    import sapg_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int STRIDE_W = 11,
    parameter int LINE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [3:0]        cfg_idx,
    input  logic [7:0]        cfg_wdata,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              word_strobe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PAN_W-1:0]  pan_count,
    output logic              screen_sel
);

    logic [ADDR_W-1:0]   pend_s1;
    logic [ADDR_W-1:0]   act_s2;
    logic [STRIDE_W-1:0] act_stride;
    logic [LINE_W-1:0]   act_split;
    logic [PAN_W-1:0]    act_pan1;
    logic [PAN_W-1:0]    act_pan2;
    logic [DEPTH_W-1:0]  act_depth;

    sapg_cfg_regs #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LINE_W(LINE_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_idx(cfg_idx), .wr_data(cfg_wdata),
        .frame_start(frame_start),
        .pend_s1(pend_s1), .act_s2(act_s2), .act_stride(act_stride),
        .act_split(act_split), .act_pan1(act_pan1), .act_pan2(act_pan2),
        .act_depth(act_depth)
    );

    sapg_line_walker #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LINE_W(LINE_W)
    ) walk_i (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .line_start(line_start), .word_strobe(word_strobe),
        .s1_start(pend_s1), .s2_start(act_s2), .stride(act_stride),
        .split_line(act_split),
        .word_addr(mem_addr), .screen(screen_sel)
    );

    sapg_pan_sel pan_i (
        .screen(screen_sel), .pan1(act_pan1), .pan2(act_pan2),
        .depth(act_depth), .pan_out(pan_count)
    );

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mem_addr == $past(pend_s1) && !screen_sel)); // R2

    AST_DEEP_NO_PAN: assert property (@(posedge clk) disable iff (!rst_n)
        (act_depth >= 3'd4) |-> pan_count == '0); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (mem_addr == '0 && pan_count == '0 && !screen_sel)); // R1

endmodule

// File: tb/scanline_addr_pan_gen_tb_top.sv
// Self-checking bench: a table of strobe/write vectors with expected
// outputs, then directed tests for wrap, depth masks, priority and reset.
module scanline_addr_pan_gen_tb_top;

    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [3:0]        cfg_idx = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              frame_start = 1'b0;
    logic              line_start = 1'b0;
    logic              word_strobe = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        pan_count;
    logic              screen_sel;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    scanline_addr_pan_gen #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .line_start(line_start), .word_strobe(word_strobe),
        .mem_addr(mem_addr), .pan_count(pan_count), .screen_sel(screen_sel)
    );

    // op: 0 write, 1 frame, 2 line, 3 word
    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  idx;
        logic [7:0]  dat;
        logic [19:0] addr;
        logic [3:0]  pan;
        logic        scr;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd0,  8'h40, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd1,  8'h00, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd2,  8'h53, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd3,  8'h01, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd4,  8'h00, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd5,  8'h10, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd6,  8'h00, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd8,  8'h00, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd9,  8'h80, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd10, 8'h02, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd12, 8'h03, 20'h00000, 4'h0, 1'b0},
        '{2'd0, 4'd13, 8'h00, 20'h00000, 4'h0, 1'b0},
        '{2'd1, 4'd0,  8'h00, 20'h01000, 4'h3, 1'b0},
        '{2'd3, 4'd0,  8'h00, 20'h01001, 4'h3, 1'b0},
        '{2'd3, 4'd0,  8'h00, 20'h01002, 4'h3, 1'b0},
        '{2'd2, 4'd0,  8'h00, 20'h01040, 4'h3, 1'b0},
        '{2'd3, 4'd0,  8'h00, 20'h01041, 4'h3, 1'b0},
        '{2'd2, 4'd0,  8'h00, 20'h01080, 4'h3, 1'b0},
        '{2'd2, 4'd0,  8'h00, 20'h28000, 4'h5, 1'b1},
        '{2'd3, 4'd0,  8'h00, 20'h28001, 4'h5, 1'b1},
        '{2'd2, 4'd0,  8'h00, 20'h28040, 4'h5, 1'b1},
        '{2'd0, 4'd3,  8'h03, 20'h28040, 4'h5, 1'b1},
        '{2'd0, 4'd0,  8'hFF, 20'h28040, 4'h5, 1'b1},
        '{2'd0, 4'd1,  8'h07, 20'h28040, 4'h5, 1'b1},
        '{2'd2, 4'd0,  8'h00, 20'h28080, 4'h5, 1'b1},
        '{2'd1, 4'd0,  8'h00, 20'h01000, 4'h1, 1'b0},
        '{2'd2, 4'd0,  8'h00, 20'h017FF, 4'h1, 1'b0}
    };

    task automatic check(input string tag, input logic [ADDR_W-1:0] ea,
                         input logic [3:0] ep, input logic es);
        n_total++;
        if (mem_addr !== ea || pan_count !== ep || screen_sel !== es) begin
            n_fail++;
            $display("FAIL %s: addr/pan/scr actual %h/%h/%b expected %h/%h/%b",
                     tag, mem_addr, pan_count, screen_sel, ea, ep, es);
        end
    endtask

    // One clock of stimulus, driven and released at falling edges
    task automatic drive(input bit fs, input bit ls, input bit ws,
                         input bit we, input logic [3:0] ix, input logic [7:0] d);
        @(negedge clk);
        frame_start = fs; line_start = ls; word_strobe = ws;
        cfg_wr_en = we; cfg_idx = ix; cfg_wdata = d;
        @(negedge clk);
        frame_start = 1'b0; line_start = 1'b0; word_strobe = 1'b0;
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] ix, input logic [7:0] d);
        drive(1'b0, 1'b0, 1'b0, 1'b1, ix, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 20'h0, 4'h0, 1'b0);
        rst_n = 1'b1;

        // Table walk (R2 frame, R3 word, R4 line, R5 split, R7 staging, R8 map)
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: drive(1'b0, 1'b0, 1'b0, 1'b1, VEC[i].idx, VEC[i].dat);
                2'd1: drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
                2'd2: drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
                default: drive(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'd0);
            endcase
            case (VEC[i].op)
                2'd0: check($sformatf("R7 R8 vec %0d", i), VEC[i].addr, VEC[i].pan, VEC[i].scr);
                2'd1: check($sformatf("R2 R6 vec %0d", i), VEC[i].addr, VEC[i].pan, VEC[i].scr);
                2'd2: check($sformatf("R4 R5 vec %0d", i), VEC[i].addr, VEC[i].pan, VEC[i].scr);
                default: check($sformatf("R3 vec %0d", i), VEC[i].addr, VEC[i].pan, VEC[i].scr);
            endcase
        end

        // Address wrap and no-split (stride 0x7FF, depth 8 bpp, pan {5,3})
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); wr(4'd6, 8'h0F); wr(4'd12, 8'h00);
        check("R7 staged", 20'h017FF, 4'h1, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R2 top start", 20'hFFFFF, 4'h1, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'd0);
        check("R3 word wrap", 20'h00000, 4'h1, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R4 line wrap", 20'h007FE, 4'h1, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R5 split zero", 20'h017FC, 4'h1, 1'b0);

        // Depth masks
        wr(4'd3, 8'h04); wr(4'd2, 8'hFF);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R6 16bpp", 20'hFFFFF, 4'h0, 1'b0);
        wr(4'd3, 8'h02);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R6 4bpp", 20'hFFFFF, 4'h3, 1'b0);
        wr(4'd3, 8'h00);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R6 1bpp", 20'hFFFFF, 4'hF, 1'b0);

        // Write coinciding with frame start is not taken
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 8'h11);
        check("R7 same cycle", 20'hFFFFF, 4'hF, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R7 next frame", 20'hFFFFF, 4'h1, 1'b0);

        // Strobe priority
        drive(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'd0);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'd0);
        check("R9 frame wins", 20'hFFFFF, 4'h1, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 8'd0);
        check("R9 line wins", 20'h007FE, 4'h1, 1'b0);

        // Unused indices are ignored
        wr(4'd7, 8'hFF); wr(4'd11, 8'hFF); wr(4'd14, 8'hFF); wr(4'd15, 8'hFF);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R8 unused frame", 20'hFFFFF, 4'h1, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R8 unused line", 20'h007FE, 4'h1, 1'b0);

        // Reset mid-run clears outputs and settings
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset run", 20'h0, 4'h0, 1'b0);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R1 cleared cfg", 20'h0, 4'h0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
        check("R1 zero stride", 20'h0, 4'h0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule